// File: doc/BRIEF.md
# PTP System Time Counter

This block keeps a free-running time of day for precision time stamping, as a seconds count and a sub-second count. On every edge of the reference clock a programmable 8-bit increment is added to the sub-second accumulator. When the accumulator passes the end of one second, it wraps and carries one into the seconds count. A mode input selects how the sub-second value rolls over. In decimal mode it counts nanoseconds at 1 ns resolution and wraps at one billion. In binary mode it is a 31-bit fraction of a second, so each unit is about 0.465 ns. With a 50 MHz reference clock the correct increment is 20 in decimal mode and 43 in binary mode.

The bus clock domain gets a read-only copy of the time. A three-state machine in the reference domain handles the transfer:
- `ST_LOAD` captures seconds and sub-seconds together and moves to `ST_WAIT_ACK`, raising a request.
- `ST_WAIT_ACK` waits for the synchronised acknowledge. When it arrives, the request drops and the machine moves to `ST_WAIT_CLR`.
- `ST_WAIT_CLR` waits for the acknowledge to fall, then returns to `ST_LOAD`.

The bus side loads the captured pair once for each request. The copy therefore updates continuously but trails the live counter by the handshake latency.

The rollover point, the fraction width and the seconds width are parameters. A bench can use small values for them.

Top module: `ptp_sys_time`

## Requirements
- R1: After reset, the seconds and sub-second values read on the bus side are zero.
- R2: In decimal mode (`ns_mode`=1), each reference clock edge adds `sub_inc` to the sub-second value. The value stays below DEC_WRAP (1,000,000,000 by default) while it starts below it.
- R3: In decimal mode, when the sum reaches or passes DEC_WRAP, the sub-second value becomes the sum minus DEC_WRAP and the seconds count increases by one.
- R4: In binary mode (`ns_mode`=0), the sub-second value is a FRAC_W-bit fraction (31 by default). A sum past 2^FRAC_W-1 wraps modulo 2^FRAC_W and increases the seconds count by one.
- R5: An increment of zero freezes the time, provided the sub-second value is valid for the current mode.
- R6: A change of `ns_mode` takes effect at the next reference clock edge. The current value gets no other correction.
- R7: The seconds count (SEC_W bits, 32 by default) wraps from all ones to zero on a carry.
- R8: The bus-side seconds and sub-seconds always come from the same reference-clock instant. They change only when a new captured pair arrives, and the captured pair stays stable while its request is pending.
- R9: Once the counter is frozen, the bus-side value equals the live value within a bounded number of bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that drives the counter |
| ref_rst_n | input | 1 | Active-low reset, reference domain |
| sub_inc | input | 8 | Sub-second increment added on each reference edge |
| ns_mode | input | 1 | 1: decimal nanosecond rollover, 0: binary fraction |
| bus_clk | input | 1 | Bus clock for the read-side copy |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| bus_sec | output | SEC_W | Seconds as seen in the bus domain |
| bus_subsec | output | max(FRAC_W, clog2(DEC_WRAP)) | Sub-seconds as seen in the bus domain |

## Verification
The counter is run in decimal mode with small and large increments. The small increment shows plain accumulation. The large increment forces the subtract-and-carry path. A zero increment shows that the value holds. Binary mode with mid and maximum increments separates modulo-power-of-two wrapping from decimal wrapping. A switch back to decimal shows that the mode change is applied without correcting the value. A long run past the seconds width shows the seconds wrap. During a live run with an increment of 3, every bus-side sample is checked to lie on the lattice of reachable values and never to go backwards. A pair with seconds and sub-seconds from different instants would fall off that lattice.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;

    localparam int INC_W = 8;

    typedef enum logic [1:0] {
        ST_LOAD     = 2'd0,
        ST_WAIT_ACK = 2'd1,
        ST_WAIT_CLR = 2'd2
    } xfer_state_e;

    function automatic int sub_width(input int frac_w, input int dec_wrap);
        int dw;
        dw = $clog2(dec_wrap);
        return (frac_w > dw) ? frac_w : dw;
    endfunction

endpackage

// File: rtl/ptp_subsec_accum.sv
module ptp_subsec_accum #(
    parameter int SUB_W    = 31,
    parameter int FRAC_W   = 31,
    parameter int DEC_WRAP = 1000000000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ptp_time_pkg::INC_W-1:0] inc,
    input  logic                           dec_mode,
    output logic [SUB_W-1:0]               sub_q,
    output logic                           carry
);
    import ptp_time_pkg::*;

    localparam logic [SUB_W:0] WRAP_C   = DEC_WRAP[SUB_W:0];
    localparam logic [SUB_W:0] BIN_MASK = (({{SUB_W{1'b0}}, 1'b1}) << FRAC_W) - 1'b1;

    logic [SUB_W:0]   sum;
    logic [SUB_W:0]   dec_val;
    logic [SUB_W:0]   bin_val;
    logic [SUB_W-1:0] sub_d;
    logic             dec_carry;
    logic             bin_carry;

    always_comb begin
        sum       = {1'b0, sub_q} + {{(SUB_W + 1 - INC_W){1'b0}}, inc};
        dec_carry = (sum >= WRAP_C);
        dec_val   = dec_carry ? (sum - WRAP_C) : sum;
        bin_carry = sum[FRAC_W];
        bin_val   = sum & BIN_MASK;
        if (dec_mode) begin
            sub_d = dec_val[SUB_W-1:0];
            carry = dec_carry;
        end else begin
            sub_d = bin_val[SUB_W-1:0];
            carry = bin_carry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sub_q <= '0;
        else        sub_q <= sub_d;
    end

    // R2
    dec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_mode && ({1'b0, sub_q} < WRAP_C)) |=> ({1'b0, sub_q} < WRAP_C));

    // R5
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((inc == '0) && (!dec_mode || ({1'b0, sub_q} < WRAP_C))) |=> $stable(sub_q));

    // R4
    bin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_mode) |=> (({1'b0, sub_q} & ~BIN_MASK) == '0));

endmodule

// File: rtl/ptp_seconds_cnt.sv
module ptp_seconds_cnt #(
    parameter int SEC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carry,
    output logic [SEC_W-1:0] sec_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sec_q <= '0;
        else if (carry) sec_q <= sec_q + 1'b1;
    end

    // R3 R7
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (sec_q == $past(sec_q) + 1'b1));

    // R5
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carry |=> $stable(sec_q));

endmodule

// File: rtl/ptp_time_xfer.sv
module ptp_time_xfer #(
    parameter int W      = 63,
    parameter int STAGES = 2
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_data,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_data
);
    import ptp_time_pkg::*;

    xfer_state_e      state_q;
    xfer_state_e      state_d;
    logic             req_q;
    logic [W-1:0]     snap_q;
    logic [STAGES-1:0] ack_sync;
    logic [STAGES-1:0] req_sync;
    logic             ack_q;
    logic             ack_s;
    logic             req_s;

    assign ack_s = ack_sync[STAGES-1];
    assign req_s = req_sync[STAGES-1];

    // source side: acknowledge synchroniser
    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) ack_sync <= '0;
        else            ack_sync <= {ack_sync[STAGES-2:0], ack_q};
    end

    // state register
    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) state_q <= ST_LOAD;
        else            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:     state_d = ST_WAIT_ACK;
            ST_WAIT_ACK: if (ack_s)  state_d = ST_WAIT_CLR;
            ST_WAIT_CLR: if (!ack_s) state_d = ST_LOAD;
            default:     state_d = ST_LOAD;
        endcase
    end

    // outputs of the source machine
    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            req_q  <= 1'b0;
            snap_q <= '0;
        end else begin
            req_q <= (state_d == ST_WAIT_ACK);
            if (state_q == ST_LOAD) snap_q <= src_data;
        end
    end

    // destination side
    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            req_sync <= '0;
            ack_q    <= 1'b0;
            dst_data <= '0;
        end else begin
            req_sync <= {req_sync[STAGES-2:0], req_q};
            ack_q    <= req_s;
            if (req_s && !ack_q) dst_data <= snap_q;
        end
    end

    // R8
    snap_hold_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        req_q |=> $stable(snap_q));

    // R8
    req_state_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        (state_q == ST_WAIT_CLR) |-> !req_q);

    // R8
    dst_hold_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        (!req_s || ack_q) |=> $stable(dst_data));

endmodule

// File: rtl/ptp_sys_time.sv
module ptp_sys_time #(
    parameter int SEC_W    = 32,
    parameter int FRAC_W   = 31,
    parameter int DEC_WRAP = 1000000000
) (
    input  logic                                                  ref_clk,
    input  logic                                                  ref_rst_n,
    input  logic [ptp_time_pkg::INC_W-1:0]                        sub_inc,
    input  logic                                                  ns_mode,
    input  logic                                                  bus_clk,
    input  logic                                                  bus_rst_n,
    output logic [SEC_W-1:0]                                      bus_sec,
    output logic [ptp_time_pkg::sub_width(FRAC_W, DEC_WRAP)-1:0]  bus_subsec
);
    localparam int SUB_W = ptp_time_pkg::sub_width(FRAC_W, DEC_WRAP);
    localparam int XW    = SEC_W + SUB_W;

    logic [SUB_W-1:0] sub_live;
    logic [SEC_W-1:0] sec_live;
    logic             carry;
    logic [XW-1:0]    xfer_out;

    ptp_subsec_accum #(
        .SUB_W    (SUB_W),
        .FRAC_W   (FRAC_W),
        .DEC_WRAP (DEC_WRAP)
    ) u_accum (
        .clk      (ref_clk),
        .rst_n    (ref_rst_n),
        .inc      (sub_inc),
        .dec_mode (ns_mode),
        .sub_q    (sub_live),
        .carry    (carry)
    );

    ptp_seconds_cnt #(
        .SEC_W (SEC_W)
    ) u_sec (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .carry (carry),
        .sec_q (sec_live)
    );

    ptp_time_xfer #(
        .W      (XW),
        .STAGES (2)
    ) u_xfer (
        .src_clk   (ref_clk),
        .src_rst_n (ref_rst_n),
        .src_data  ({sec_live, sub_live}),
        .dst_clk   (bus_clk),
        .dst_rst_n (bus_rst_n),
        .dst_data  (xfer_out)
    );

    assign bus_sec    = xfer_out[XW-1:SUB_W];
    assign bus_subsec = xfer_out[SUB_W-1:0];

endmodule

// File: tb/sim_ptp_sys_time.sv
module sim_ptp_sys_time;
    localparam int SEC_W    = 6;
    localparam int FRAC_W   = 10;
    localparam int DEC_WRAP = 1000;
    localparam int SUB_W    = 10;

    logic             ref_clk = 1'b0;
    logic             bus_clk = 1'b0;
    logic             ref_rst_n = 1'b0;
    logic             bus_rst_n = 1'b0;
    logic [7:0]       sub_inc = 8'd0;
    logic             ns_mode = 1'b1;
    logic [SEC_W-1:0] bus_sec;
    logic [SUB_W-1:0] bus_subsec;

    always #10 ref_clk = ~ref_clk;
    always #5  bus_clk = ~bus_clk;

    ptp_sys_time #(.SEC_W(SEC_W), .FRAC_W(FRAC_W), .DEC_WRAP(DEC_WRAP)) u0 (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .sub_inc(sub_inc), .ns_mode(ns_mode),
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_sec(bus_sec), .bus_subsec(bus_subsec)
    );

    int n_chk = 0;
    int n_bad = 0;
    int m_sec = 0;
    int m_sub = 0;
    bit done  = 1'b0;

    // fields: [28] decimal mode, [27:20] increment, [19:4] ref cycles, [3:0] requirement number
    localparam logic [28:0] VEC [6] = '{
        {1'b1, 8'd20,  16'd10, 4'd2},  // R2 plain decimal accumulation
        {1'b1, 8'd250, 16'd5,  4'd3},  // R3 decimal subtract and carry
        {1'b1, 8'd0,   16'd20, 4'd5},  // R5 zero increment holds
        {1'b0, 8'd43,  16'd30, 4'd4},  // R4 binary fraction wrap
        {1'b0, 8'd255, 16'd9,  4'd4},  // R4 binary with maximum increment
        {1'b1, 8'd7,   16'd5,  4'd6}   // R6 switch back to decimal
    };

    task automatic check(input string tag, input int got_s, input int got_sub);
        n_chk++;
        if (got_s != m_sec || got_sub != m_sub) begin
            n_bad++;
            $display("FAIL %s: got sec=%0d sub=%0d expected sec=%0d sub=%0d",
                     tag, got_s, got_sub, m_sec, m_sub);
        end
    endtask

    task automatic model_step(input bit dec, input int inc);
        int sum;
        bit c;
        sum = m_sub + inc;
        c = 1'b0;
        if (dec) begin
            if (sum >= DEC_WRAP) begin sum = sum - DEC_WRAP; c = 1'b1; end
        end else begin
            if (sum >= (1 << FRAC_W)) begin sum = sum - (1 << FRAC_W); c = 1'b1; end
        end
        m_sub = sum;
        if (c) m_sec = (m_sec + 1) % (1 << SEC_W);
    endtask

    task automatic run(input bit dec, input int inc, input int cycles);
        @(negedge ref_clk);
        ns_mode = dec;
        sub_inc = inc[7:0];
        for (int k = 0; k < cycles; k++) begin
            @(negedge ref_clk);
            model_step(dec, inc);
        end
        sub_inc = 8'd0;
    endtask

    task automatic settle();
        repeat (60) @(negedge bus_clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge bus_clk);
        // R1 reset values
        check("R1", int'(bus_sec), int'(bus_subsec));
        ref_rst_n = 1'b1;
        bus_rst_n = 1'b1;
        settle();
        check("R1", int'(bus_sec), int'(bus_subsec));

        for (int i = 0; i < 6; i++) begin
            run(VEC[i][28], int'(VEC[i][27:20]), int'(VEC[i][19:4]));
            settle();
            // R9 settled bus value equals the live model
            check($sformatf("R%0d", VEC[i][3:0]), int'(bus_sec), int'(bus_subsec));
        end

        // R7 seconds wrap from all ones to zero
        run(1'b1, 250, 300);
        settle();
        check("R7", int'(bus_sec), int'(bus_subsec));

        // R8 coherence while running: samples stay on the step-3 lattice and never go back
        begin
            int base;
            int prev;
            int bad8;
            bad8 = 0;
            base = m_sec * DEC_WRAP + m_sub;
            prev = base;
            fork
                run(1'b1, 3, 300);
                begin
                    for (int k = 0; k < 500; k++) begin
                        int lin;
                        @(negedge bus_clk);
                        lin = int'(bus_sec) * DEC_WRAP + int'(bus_subsec);
                        if (lin < prev || ((lin - base) % 3) != 0 || int'(bus_subsec) >= DEC_WRAP) begin
                            if (bad8 == 0)
                                $display("FAIL R8: got linear=%0d expected >=%0d on step 3 from %0d",
                                         lin, prev, base);
                            bad8++;
                        end
                        prev = lin;
                    end
                end
            join
            n_chk++;
            if (bad8 != 0) n_bad++;
        end
        settle();
        // R9 after coherence run
        check("R9", int'(bus_sec), int'(bus_subsec));

        // R5 frozen value holds over a long wait
        settle();
        check("R5", int'(bus_sec), int'(bus_subsec));

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule